// File: doc/BRIEF.md
# Banked Memory Cycle Sequencer

This block runs a fixed twelve-pulse memory cycle against a word store made of one writable bank and a set of read-only banks. An external timing-pulse index (1 to 12) steps the cycle, and cycles follow one another without gaps. Each cycle has three phases. The target address is captured in pulse 1. The addressed word is then moved into a buffer register. In the last phase the buffer goes back into the store. Every cycle therefore reads a location and then restores it. Writable words reach the buffer one pulse earlier than read-only words.

A 12-bit address is split into a 10-bit offset and a 2-bit bank selector. Three selector codes name the writable bank and the two always-present read-only banks. The fourth code reaches any bank through a 5-bit bank register. The datapath can see the buffer, and overwrite it, only in a four-pulse window. The stored word carries an odd-parity bit. Every load checks that bit, and a failed check sets a sticky alarm.

Each pulse index is held for one clock. A registered action named for pulse N happens at the clock edge that ends pulse N.

Top module: `mem_cycle_seq`

## Requirements
- R1: `addr_i` is sampled only at the edge ending pulse 1; values on it during pulses 2 to 12 do not change which word the cycle reads.
- R2: Address bits [11:10] select the bank. 2'b00 is the writable bank 0, 2'b01 is read-only bank 1 and 2'b10 is read-only bank 2. 2'b11 uses the bank register; a register value of 0 or 1 reaches bank 1 and a value of 2 reaches bank 2. Selectors 01 and 10 ignore the register. `bank_we_i` loads `bank_i` into the register at the next edge.
- R3: A read-only word in bank b at offset o carries data {b[4:0], o[9:0]}, with the bank in data bits [14:10]. Its bit 15 is set so that the 16-bit word has an odd number of ones.
- R4: `buf_vld_o` is high exactly while the pulse index is 7 to 10. In that window `buf_o` shows buffer bits [14:0]; at every other pulse `buf_o` is zero.
- R5: A buffer write (`buf_we_i`) at a pulse from 7 to 10 replaces the buffer and is visible on `buf_o` from the next pulse. A write at any other pulse is ignored.
- R6: At the edge ending pulse 11 the buffer, modified or not, is stored back to the addressed writable location, and a later cycle to that address reads it.
- R7: Write-back to a read-only bank is suppressed, so a read-only word reads the same after a cycle that modified the buffer.
- R8: With `buf_raw_i` low, a buffer write stores `buf_wd_i[14:0]` with a generated odd-parity bit. With it high, all 16 bits of `buf_wd_i` are stored exactly as given.
- R9: When a loaded word (at the edge ending pulse 5 for the writable bank, pulse 6 for read-only banks) has an even count of ones, `par_alarm_o` rises. It stays high until `par_clr_i` is asserted in a cycle with no new failure.
- R10: After reset the buffer, the bank register and the alarm are zero. Writable words power up as data zero with parity bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tp_i | input | 4 | Timing-pulse index, 1 to 12 |
| addr_i | input | 12 | Cycle address, sampled at pulse 1 |
| bank_we_i | input | 1 | Bank register write strobe |
| bank_i | input | 5 | Bank register write value |
| buf_we_i | input | 1 | Buffer modify strobe |
| buf_raw_i | input | 1 | Store buf_wd_i as given, parity bit included |
| buf_wd_i | input | 16 | Buffer modify data |
| par_clr_i | input | 1 | Parity alarm clear |
| buf_o | output | 15 | Buffer data, zero outside the window |
| buf_vld_o | output | 1 | Buffer window active |
| par_alarm_o | output | 1 | Sticky parity alarm |

## Verification
The assertions check these rules on every cycle:
- the address register holds outside pulse 1;
- the buffer is frozen at the pulses where no load or modify may happen;
- a bank register write lands;
- a parity failure raises the alarm, and the alarm stays up until cleared.

Word contents need multi-cycle directed scenarios, which only the bench provides. These cover the read-only data pattern, the four bank-select codes with register aliasing, write-back into the writable bank, and suppressed write-back into read-only banks. The bench also shows that a raw even-parity word stored in one cycle is flagged on the next read.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic [1:0] {
    SEL_ERAS = 2'd0,
    SEL_FIX1 = 2'd1,
    SEL_FIX2 = 2'd2,
    SEL_BREG = 2'd3
  } bank_sel_e;
endpackage

// File: rtl/mcs_decode.sv
module mcs_decode import mcs_pkg::*; #(
  parameter int OFF_W  = 10,
  parameter int BANK_W = 5
) (
  input  logic [OFF_W+1:0]  addr_i,
  input  logic [BANK_W-1:0] bank_reg_i,
  output logic [OFF_W-1:0]  off_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              eras_o
);
  bank_sel_e sel;
  assign sel   = bank_sel_e'(addr_i[OFF_W+1:OFF_W]);
  assign off_o = addr_i[OFF_W-1:0];

  always_comb begin
    eras_o = 1'b0;
    bank_o = BANK_W'(1);
    unique case (sel)
      SEL_ERAS: begin eras_o = 1'b1; bank_o = '0; end
      SEL_FIX1: bank_o = BANK_W'(1);
      SEL_FIX2: bank_o = BANK_W'(2);
      SEL_BREG: bank_o = (bank_reg_i == '0) ? BANK_W'(1) : bank_reg_i;
      default:  bank_o = BANK_W'(1);
    endcase
  end
endmodule

// File: rtl/mcs_erasable.sv
module mcs_erasable #(
  parameter int OFF_W  = 10,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [OFF_W-1:0]  addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << OFF_W;
  logic [WORD_W-1:0] mem [DEPTH];

  // power-up content: data zero, odd parity
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = {1'b1, {(WORD_W-1){1'b0}}};
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/mcs_parity_alarm.sv
module mcs_parity_alarm #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chk_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              clr_i,
  output logic              alarm_o
);
  logic bad;
  assign bad = chk_i && !(^word_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     alarm_o <= 1'b0;
    else if (bad)    alarm_o <= 1'b1;
    else if (clr_i)  alarm_o <= 1'b0;
  end

  p_alarm_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_i && !(^word_i)) |=> alarm_o);

  p_alarm_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o && !clr_i) |=> alarm_o);
endmodule

// File: rtl/mem_cycle_seq.sv
module mem_cycle_seq import mcs_pkg::*; #(
  parameter int OFF_W     = 10,
  parameter int BANK_W    = 5,
  parameter int TP_W      = 4,
  parameter int ADDR_TP   = 1,
  parameter int ERAS_TP   = 6,
  parameter int FIX_TP    = 7,
  parameter int WIN_LO_TP = 7,
  parameter int WIN_HI_TP = 10,
  parameter int WB_TP     = 11
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [TP_W-1:0]        tp_i,
  input  logic [OFF_W+1:0]       addr_i,
  input  logic                   bank_we_i,
  input  logic [BANK_W-1:0]      bank_i,
  input  logic                   buf_we_i,
  input  logic                   buf_raw_i,
  input  logic [BANK_W+OFF_W:0]  buf_wd_i,
  input  logic                   par_clr_i,
  output logic [BANK_W+OFF_W-1:0] buf_o,
  output logic                   buf_vld_o,
  output logic                   par_alarm_o
);
  localparam int DATA_W = BANK_W + OFF_W;
  localparam int WORD_W = DATA_W + 1;
  localparam int ADDR_W = OFF_W + 2;
  localparam logic [TP_W-1:0] TP_ADDR = TP_W'(ADDR_TP);
  localparam logic [TP_W-1:0] TP_LDE  = TP_W'(ERAS_TP - 1);
  localparam logic [TP_W-1:0] TP_LDF  = TP_W'(FIX_TP - 1);
  localparam logic [TP_W-1:0] TP_WLO  = TP_W'(WIN_LO_TP);
  localparam logic [TP_W-1:0] TP_WHI  = TP_W'(WIN_HI_TP);
  localparam logic [TP_W-1:0] TP_WB   = TP_W'(WB_TP);

  logic [ADDR_W-1:0] addr_q;
  logic [BANK_W-1:0] bank_q;
  logic [WORD_W-1:0] buf_q;
  logic [OFF_W-1:0]  off;
  logic [BANK_W-1:0] bank_eff;
  logic              eras;
  logic [WORD_W-1:0] ram_rdata;
  logic [WORD_W-1:0] rom_word;
  logic [WORD_W-1:0] mod_word;
  logic              load_e, load_f, in_win, mod_en, ram_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              addr_q <= '0;
    else if (tp_i == TP_ADDR) addr_q <= addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        bank_q <= '0;
    else if (bank_we_i) bank_q <= bank_i;
  end

  mcs_decode #(.OFF_W(OFF_W), .BANK_W(BANK_W)) u_decode (
    .addr_i     (addr_q),
    .bank_reg_i (bank_q),
    .off_o      (off),
    .bank_o     (bank_eff),
    .eras_o     (eras)
  );

  mcs_erasable #(.OFF_W(OFF_W), .WORD_W(WORD_W)) u_eras (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .addr_i  (off),
    .wdata_i (buf_q),
    .rdata_o (ram_rdata)
  );

  // read-only content is a pure function of bank and offset
  assign rom_word = {~^{bank_eff, off}, bank_eff, off};

  assign load_e = (tp_i == TP_LDE) && eras;
  assign load_f = (tp_i == TP_LDF) && !eras;
  assign in_win = (tp_i >= TP_WLO) && (tp_i <= TP_WHI);
  assign mod_en = buf_we_i && in_win;
  assign ram_we = (tp_i == TP_WB) && eras;
  assign mod_word = buf_raw_i ? buf_wd_i
                              : {~^buf_wd_i[DATA_W-1:0], buf_wd_i[DATA_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     buf_q <= '0;
    else if (load_e) buf_q <= ram_rdata;
    else if (load_f) buf_q <= rom_word;
    else if (mod_en) buf_q <= mod_word;
  end

  mcs_parity_alarm #(.WORD_W(WORD_W)) u_par (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .chk_i   (load_e || load_f),
    .word_i  (load_e ? ram_rdata : rom_word),
    .clr_i   (par_clr_i),
    .alarm_o (par_alarm_o)
  );

  assign buf_vld_o = in_win;
  assign buf_o     = in_win ? buf_q[DATA_W-1:0] : '0;

  p_addr_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tp_i != TP_ADDR) |=> $stable(addr_q));

  p_bank_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_we_i |=> (bank_q == $past(bank_i)));

  p_buf_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tp_i < TP_LDE || tp_i > TP_WHI) |=> $stable(buf_q));
endmodule

// File: tb/mem_cycle_seq_bench.sv
module mem_cycle_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  tp_i = 4'd12;
  logic [11:0] addr_i = '0;
  logic        bank_we_i = 1'b0;
  logic [4:0]  bank_i = '0;
  logic        buf_we_i = 1'b0;
  logic        buf_raw_i = 1'b0;
  logic [15:0] buf_wd_i = '0;
  logic        par_clr_i = 1'b0;
  logic [14:0] buf_o;
  logic        buf_vld_o;
  logic        par_alarm_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  mem_cycle_seq u_mem_cycle_seq (
    .clk_i, .rst_ni, .tp_i, .addr_i, .bank_we_i, .bank_i,
    .buf_we_i, .buf_raw_i, .buf_wd_i, .par_clr_i,
    .buf_o, .buf_vld_o, .par_alarm_o
  );

  function automatic logic [14:0] rom_d(input int bank, input int off);
    return {5'(bank), 10'(off)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one full 12-pulse cycle; optional buffer write at pulse wr_p
  task automatic mem_cycle(input logic [11:0] a, input int wr_p, input logic raw,
                           input logic [15:0] wd, output logic [14:0] d7,
                           output logic [14:0] d9, output bit win_ok);
    win_ok = 1'b1;
    d7 = '0;
    d9 = '0;
    for (int p = 1; p <= 12; p++) begin
      @(negedge clk_i);
      tp_i      = 4'(p);
      addr_i    = (p == 1) ? a : ~a;
      buf_we_i  = (p == wr_p);
      buf_raw_i = raw;
      buf_wd_i  = wd;
      #1;
      if (p == 7) d7 = buf_o;
      if (p == 9) d9 = buf_o;
      if ((p < 7 || p > 10) && (buf_o != '0 || buf_vld_o)) win_ok = 1'b0;
      if (p >= 7 && p <= 10 && !buf_vld_o) win_ok = 1'b0;
    end
    buf_we_i = 1'b0;
  endtask

  task automatic set_bank(input logic [4:0] v);
    @(negedge clk_i); bank_we_i = 1'b1; bank_i = v;
    @(negedge clk_i); bank_we_i = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk(par_alarm_o == 1'b0, "R10 alarm", par_alarm_o, 0);
    chk(buf_o == '0 && !buf_vld_o, "R10 buffer", buf_o, 0);
  endtask

  task automatic t_fixed_direct;
    logic [14:0] d7, d9; bit w;
    mem_cycle({2'b01, 10'd37}, 0, 1'b0, '0, d7, d9, w);
    chk(d7 == rom_d(1, 37), "R1 R3 bank1 word", d7, rom_d(1, 37));
    chk(w, "R4 window", w, 1);
    mem_cycle({2'b10, 10'd1000}, 0, 1'b0, '0, d7, d9, w);
    chk(d7 == rom_d(2, 1000), "R2 R3 bank2 word", d7, rom_d(2, 1000));
    chk(par_alarm_o == 1'b0, "R3 read-only parity odd", par_alarm_o, 0);
  endtask

  task automatic t_bank_reg;
    logic [14:0] d7, d9; bit w;
    set_bank(5'd5);
    mem_cycle({2'b11, 10'd100}, 0, 1'b0, '0, d7, d9, w);
    chk(d7 == rom_d(5, 100), "R2 bank reg 5", d7, rom_d(5, 100));
    set_bank(5'd0);
    mem_cycle({2'b11, 10'd100}, 0, 1'b0, '0, d7, d9, w);
    chk(d7 == rom_d(1, 100), "R2 bank reg 0 alias", d7, rom_d(1, 100));
    set_bank(5'd2);
    mem_cycle({2'b11, 10'd100}, 0, 1'b0, '0, d7, d9, w);
    chk(d7 == rom_d(2, 100), "R2 bank reg 2 alias", d7, rom_d(2, 100));
    set_bank(5'd31);
    mem_cycle({2'b11, 10'd100}, 0, 1'b0, '0, d7, d9, w);
    chk(d7 == rom_d(31, 100), "R2 bank reg 31", d7, rom_d(31, 100));
    mem_cycle({2'b01, 10'd100}, 0, 1'b0, '0, d7, d9, w);
    chk(d7 == rom_d(1, 100), "R2 fixed-fixed ignores reg", d7, rom_d(1, 100));
  endtask

  task automatic t_erasable;
    logic [14:0] d7, d9; bit w;
    mem_cycle({2'b00, 10'd5}, 8, 1'b0, 16'h1234, d7, d9, w);
    chk(d7 == '0, "R10 erasable power-up", d7, 0);
    chk(d9 == 15'h1234, "R5 modify visible", d9, 16'h1234);
    chk(w, "R4 window erasable", w, 1);
    mem_cycle({2'b00, 10'd5}, 11, 1'b0, 16'h7777, d7, d9, w);
    chk(d7 == 15'h1234, "R6 writeback", d7, 16'h1234);
    chk(par_alarm_o == 1'b0, "R8 generated parity", par_alarm_o, 0);
    mem_cycle({2'b00, 10'd5}, 6, 1'b0, 16'h2222, d7, d9, w);
    chk(d7 == 15'h1234, "R5 late write ignored", d7, 16'h1234);
    chk(d9 == 15'h1234, "R5 early write ignored", d9, 16'h1234);
    mem_cycle({2'b00, 10'd5}, 0, 1'b0, '0, d7, d9, w);
    chk(d7 == 15'h1234, "R5 R6 content kept", d7, 16'h1234);
  endtask

  task automatic t_fixed_nowrite;
    logic [14:0] d7, d9; bit w;
    mem_cycle({2'b01, 10'd37}, 8, 1'b0, 16'h0555, d7, d9, w);
    chk(d9 == 15'h0555, "R5 read-only buffer modify", d9, 16'h0555);
    mem_cycle({2'b01, 10'd37}, 0, 1'b0, '0, d7, d9, w);
    chk(d7 == rom_d(1, 37), "R7 read-only unchanged", d7, rom_d(1, 37));
  endtask

  task automatic t_parity;
    logic [14:0] d7, d9; bit w;
    mem_cycle({2'b00, 10'd10}, 8, 1'b1, 16'h0007, d7, d9, w);
    mem_cycle({2'b00, 10'd10}, 0, 1'b0, '0, d7, d9, w);
    chk(d7 == 15'h0007, "R8 raw odd stored", d7, 7);
    chk(par_alarm_o == 1'b0, "R8 raw odd no alarm", par_alarm_o, 0);
    mem_cycle({2'b00, 10'd9}, 8, 1'b1, 16'h0003, d7, d9, w);
    chk(par_alarm_o == 1'b0, "R9 no alarm before reload", par_alarm_o, 0);
    mem_cycle({2'b00, 10'd9}, 0, 1'b0, '0, d7, d9, w);
    chk(d7 == 15'h0003, "R8 raw even stored", d7, 3);
    chk(par_alarm_o == 1'b1, "R9 alarm set", par_alarm_o, 1);
    mem_cycle({2'b10, 10'd3}, 0, 1'b0, '0, d7, d9, w);
    chk(par_alarm_o == 1'b1, "R9 alarm sticky", par_alarm_o, 1);
    @(negedge clk_i); par_clr_i = 1'b1;
    @(negedge clk_i); par_clr_i = 1'b0;
    #1;
    chk(par_alarm_o == 1'b0, "R9 alarm cleared", par_alarm_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_fixed_direct();
    t_bank_reg();
    t_erasable();
    t_fixed_nowrite();
    t_parity();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule